// File: doc/BRIEF.md
# Dual-Channel Hot-Swap Turn-On Sequencer

This block decides when each of two power channels may switch on its external pass transistor. It watches synchronized comparator results for both input supplies and the internal supply, and produces a power-on reset pulse once every supply is valid. After that pulse, each channel checks its own start conditions: undervoltage OK, overvoltage OK, and the active-low enable pin driven low. These conditions must hold without a break for a long debounce interval before the channel is armed.

When a channel is armed, the level of its ON pin is copied into a host-visible turn-on control bit. The gate-enable output then follows that bit, a later rising edge on the ON pin, or a write from the host. A coupling input selects between two modes. In coupled mode both channels qualify, agree and switch as a pair. In independent mode each channel runs on its own, but the two share a single start-up timer. A channel asking to start while the other channel's start-up cycle is still running must wait for the timer to finish, unless the request comes from an ON pin edge.

Top module: `hsq_dual_seq`

## Requirements
- R1: When both external supply OK inputs and the internal supply OK input are high, `por_o` goes high for exactly POR_CYCLES cycles. Sequencing runs only after that pulse. Losing any supply OK input at any time cancels readiness and a later recovery starts a new pulse.
- R2: While `por_o` is high, both gate outputs are low, and both control bits are cleared to 0 on every clock edge of the pulse.
- R3: A channel qualifies only after its start conditions (uv OK high, ov OK high, enable pin low, no fault, sequencer ready) have held for QUAL_CYCLES consecutive clocks. Any break restarts the count from zero.
- R4: On qualification the channel's control bit is loaded with its ON pin level. If that bit is 1, the gate turns on without further action.
- R5: An armed channel whose control bit is 0 turns on after the host writes 1 to the bit (`ctl_we_i` with `ctl_wd_i`=1), or after a rising edge on its ON pin.
- R6: With `couple_i`=0, neither channel arms until both have qualified. Both gates turn on in the same cycle, and only when both control bits are 1 or both ON pins are high. Losing a start condition on either channel switches both gates off.
- R7: With `couple_i`=1, each turn-on that finds the shared timer idle starts it, and it stays busy for START_CYCLES cycles. A channel whose turn-on comes from its control bit while the timer is busy (or is being claimed by channel 0 in the same cycle) holds its gate off until the timer is idle.
- R8: In independent mode, a rising ON pin edge on an armed or waiting channel turns its gate on at the next edge, even while the timer is busy.
- R9: A high `fault_i` bit clears that channel's gate at the next edge and sends the channel back to qualification.
- R10: `status_o[2c]` reports channel c's undervoltage OK input and `status_o[2c+1]` reports its overvoltage OK input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vdd_ok_i | input | 2 | External supply above UVLO, per supply |
| intvcc_ok_i | input | 1 | Internal supply above UVLO |
| uv_ok_i | input | 2 | Undervoltage comparator OK, per channel |
| ov_ok_i | input | 2 | Overvoltage comparator OK, per channel |
| en_ni | input | 2 | Enable pin, active low, per channel |
| on_i | input | 2 | ON pin level, per channel |
| fault_i | input | 2 | Fault shutdown request, per channel |
| couple_i | input | 1 | 0: channels coupled, 1: independent |
| ctl_we_i | input | 2 | Host write strobe for each channel's control bit |
| ctl_wd_i | input | 2 | Host write data for the control bits |
| ctl_on_o | output | 2 | Turn-on control bit, per channel |
| status_o | output | 4 | {ov OK, uv OK} per channel, channel 0 in bits 1:0 |
| por_o | output | 1 | Power-on reset pulse |
| gate_o | output | 2 | Gate enable, per channel |
| tmr_busy_o | output | 1 | Shared start-up timer running |

## Verification
The assertions assume that `couple_i` changes only while both channels are back in qualification with their gates off. Under that assumption the coupled-mode gates can never disagree. The assertions also assume the inputs are already synchronized, so each is sampled once per clock. The stimulus changes inputs only on the falling clock edge. Before each change of `couple_i` it first drives both enable pins inactive and waits for both gates to drop. Apart from that, it moves the start conditions and the ON pin freely, including a break in the middle of the debounce window, so the cycle-level reference model is also tested on restarts.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  localparam int unsigned NCH = 2;
  typedef enum logic [1:0] {CH_QUAL, CH_ARMED, CH_WAIT, CH_ON} ch_st_e;
  typedef enum logic [1:0] {PW_OFF, PW_PULSE, PW_RUN} pw_st_e;
endpackage

// File: rtl/hsq_por.sv
module hsq_por
  import hsq_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 11250
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] vdd_ok_i,
  input  logic           intvcc_ok_i,
  output logic           por_o,
  output logic           ready_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);

  pw_st_e        st_q;
  logic [CW-1:0] cnt_q;
  logic          ok;

  assign ok = (&vdd_ok_i) & intvcc_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PW_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        PW_OFF: if (ok) begin
          st_q  <= PW_PULSE;
          cnt_q <= CW'(POR_CYCLES - 1);
        end
        PW_PULSE: begin
          if (!ok)              st_q <= PW_OFF;
          else if (cnt_q == '0) st_q <= PW_RUN;
          else                  cnt_q <= cnt_q - 1'b1;
        end
        PW_RUN:  if (!ok) st_q <= PW_OFF;
        default: st_q <= PW_OFF;
      endcase
    end
  end

  assign por_o   = (st_q == PW_PULSE);
  assign ready_o = (st_q == PW_RUN);
endmodule

// File: rtl/hsq_qual.sv
module hsq_qual #(
  parameter int unsigned QUAL_CYCLES = 12500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] cnt_q;

  // any break restarts the debounce window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!cond_i)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == LIMIT);
endmodule

// File: rtl/hsq_timer.sv
module hsq_timer #(
  parameter int unsigned START_CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(START_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(START_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/hsq_dual_seq.sv
module hsq_dual_seq
  import hsq_pkg::*;
#(
  parameter int unsigned POR_CYCLES   = 11250,
  parameter int unsigned QUAL_CYCLES  = 12500000,
  parameter int unsigned START_CYCLES = 1250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] vdd_ok_i,
  input  logic       intvcc_ok_i,
  input  logic [1:0] uv_ok_i,
  input  logic [1:0] ov_ok_i,
  input  logic [1:0] en_ni,
  input  logic [1:0] on_i,
  input  logic [1:0] fault_i,
  input  logic       couple_i,
  input  logic [1:0] ctl_we_i,
  input  logic [1:0] ctl_wd_i,
  output logic [1:0] ctl_on_o,
  output logic [3:0] status_o,
  output logic       por_o,
  output logic [1:0] gate_o,
  output logic       tmr_busy_o
);
  logic           por, ready, tmr_start;
  logic [NCH-1:0] cond, qual, drop, load, on_q, on_rise, ctl_q, in_wait;
  ch_st_e         st_q [NCH];
  ch_st_e         st_d [NCH];
  logic           both_qual, pair_go;

  hsq_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i, .rst_ni, .vdd_ok_i, .intvcc_ok_i, .por_o(por), .ready_o(ready)
  );

  hsq_timer #(.START_CYCLES(START_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .start_i(tmr_start), .busy_o(tmr_busy_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cond[c]    = ready & uv_ok_i[c] & ov_ok_i[c] & ~en_ni[c] & ~fault_i[c];
    assign on_rise[c] = on_i[c] & ~on_q[c];
    assign drop[c]    = couple_i ? ~cond[c] : ~(&cond);
    assign gate_o[c]  = (st_q[c] == CH_ON);
    assign in_wait[c] = (st_q[c] == CH_WAIT);
    assign status_o[2*c]   = uv_ok_i[c];
    assign status_o[2*c+1] = ov_ok_i[c];

    hsq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk_i, .rst_ni, .cond_i(cond[c]), .qual_o(qual[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[c]  <= CH_QUAL;
        ctl_q[c] <= 1'b0;
        on_q[c]  <= 1'b0;
      end else begin
        st_q[c] <= st_d[c];
        on_q[c] <= on_i[c];
        if (por)              ctl_q[c] <= 1'b0;
        else if (load[c])     ctl_q[c] <= on_i[c];
        else if (ctl_we_i[c]) ctl_q[c] <= ctl_wd_i[c];
      end
    end
  end

  assign both_qual = &qual;
  assign pair_go   = (st_q[0] == CH_ARMED) && (st_q[1] == CH_ARMED) &&
                     ((&ctl_q) || (&on_i));

  // channel 0 is evaluated first and wins a simultaneous timer claim
  always_comb begin
    logic taken;
    taken     = tmr_busy_o;
    tmr_start = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      st_d[c] = st_q[c];
      load[c] = 1'b0;
      if (drop[c]) begin
        st_d[c] = CH_QUAL;
      end else begin
        unique case (st_q[c])
          CH_QUAL: if (couple_i ? qual[c] : both_qual) begin
            st_d[c] = CH_ARMED;
            load[c] = 1'b1;
          end
          CH_ARMED: begin
            if (!couple_i) begin
              if (pair_go) st_d[c] = CH_ON;
            end else if (on_rise[c]) begin
              st_d[c] = CH_ON;
            end else if (ctl_q[c]) begin
              st_d[c] = taken ? CH_WAIT : CH_ON;
            end
          end
          CH_WAIT: if (on_rise[c] || !taken) st_d[c] = CH_ON;
          default: ;
        endcase
      end
      if (st_d[c] == CH_ON && st_q[c] != CH_ON) begin
        if (!tmr_busy_o) tmr_start = 1'b1;
        taken = 1'b1;
      end
    end
  end

  assign ctl_on_o = ctl_q;
  assign por_o    = por;
endmodule

// File: rtl/hsq_dual_seq_chk.sv
module hsq_dual_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_o,
  input logic [1:0] gate_o,
  input logic [1:0] ctl_on_o,
  input logic [1:0] fault_i,
  input logic       couple_i,
  input logic       tmr_busy_o,
  input logic [1:0] qual,
  input logic [1:0] in_wait,
  input logic [1:0] on_rise
);
  // R2
  por_gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_o |-> gate_o == 2'b00);

  // R2
  por_ctl_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_o |=> ctl_on_o == 2'b00);

  // R3
  gate0_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[0]) |-> $past(qual[0]));

  // R3
  gate1_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[1]) |-> $past(qual[1]));

  // R6
  coupled_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !couple_i |-> gate_o[0] == gate_o[1]);

  // R9
  fault0_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i[0] |=> !gate_o[0]);

  // R9
  fault1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i[1] |=> !gate_o[1]);

  // R7
  wait0_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_o[0]) && $past(in_wait[0]) && !$past(on_rise[0])) |-> !$past(tmr_busy_o));

  // R7
  wait1_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_o[1]) && $past(in_wait[1]) && !$past(on_rise[1])) |-> !$past(tmr_busy_o));
endmodule

bind hsq_dual_seq hsq_dual_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_o(por_o), .gate_o(gate_o),
  .ctl_on_o(ctl_on_o), .fault_i(fault_i), .couple_i(couple_i),
  .tmr_busy_o(tmr_busy_o), .qual(qual), .in_wait(in_wait), .on_rise(on_rise)
);

// File: tb/tb_hsq_dual_seq.sv
`timescale 1ns/1ps
module tb_hsq_dual_seq;
  localparam int PC = 4;
  localparam int QC = 10;
  localparam int SC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] vdd_ok = 2'b00, uv_ok = 2'b00, ov_ok = 2'b00, en_n = 2'b11;
  logic [1:0] on_p = 2'b00, fault = 2'b00, we = 2'b00, wd = 2'b00;
  logic       intvcc_ok = 1'b0, couple = 1'b1;
  logic [1:0] ctl_on, gate;
  logic [3:0] status;
  logic       por, busy;

  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  hsq_dual_seq #(.POR_CYCLES(PC), .QUAL_CYCLES(QC), .START_CYCLES(SC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .vdd_ok_i(vdd_ok), .intvcc_ok_i(intvcc_ok),
    .uv_ok_i(uv_ok), .ov_ok_i(ov_ok), .en_ni(en_n), .on_i(on_p),
    .fault_i(fault), .couple_i(couple), .ctl_we_i(we), .ctl_wd_i(wd),
    .ctl_on_o(ctl_on), .status_o(status), .por_o(por), .gate_o(gate),
    .tmr_busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model: 0 qual, 1 armed, 2 wait, 3 on
  int m_pw = 0, m_pcnt = 0, m_busy = 0, m_tcnt = 0;
  int m_cnt[2] = '{0, 0};
  int m_st[2]  = '{0, 0};
  int m_ctl[2] = '{0, 0};
  int m_onp[2] = '{0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pw = 0; m_pcnt = 0; m_busy = 0; m_tcnt = 0;
      m_cnt = '{0, 0}; m_st = '{0, 0}; m_ctl = '{0, 0}; m_onp = '{0, 0};
    end else begin
      int  ns[2];
      bit  cnd[2], q[2], rs[2], ld[2], dr[2];
      bit  tk, st_go, ok, go_pair;
      ok = (vdd_ok == 2'b11) && intvcc_ok;
      for (int c = 0; c < 2; c++) begin
        cnd[c] = (m_pw == 2) && uv_ok[c] && ov_ok[c] && !en_n[c] && !fault[c];
        q[c]   = (m_cnt[c] == QC);
        rs[c]  = on_p[c] && (m_onp[c] == 0);
      end
      for (int c = 0; c < 2; c++) dr[c] = couple ? !cnd[c] : !(cnd[0] && cnd[1]);
      go_pair = (m_st[0] == 1) && (m_st[1] == 1) &&
                ((m_ctl[0] == 1 && m_ctl[1] == 1) || on_p == 2'b11);
      tk = (m_busy != 0); st_go = 0;
      for (int c = 0; c < 2; c++) begin
        ns[c] = m_st[c]; ld[c] = 0;
        if (dr[c]) ns[c] = 0;
        else if (m_st[c] == 0) begin
          if (couple ? q[c] : (q[0] && q[1])) begin ns[c] = 1; ld[c] = 1; end
        end else if (m_st[c] == 1) begin
          if (!couple) begin if (go_pair) ns[c] = 3; end
          else if (rs[c]) ns[c] = 3;
          else if (m_ctl[c] == 1) ns[c] = tk ? 2 : 3;
        end else if (m_st[c] == 2) begin
          if (rs[c] || !tk) ns[c] = 3;
        end
        if (ns[c] == 3 && m_st[c] != 3) begin
          if (m_busy == 0) st_go = 1;
          tk = 1;
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (m_pw == 1) m_ctl[c] = 0;
        else if (ld[c]) m_ctl[c] = on_p[c];
        else if (we[c]) m_ctl[c] = wd[c];
        m_cnt[c] = !cnd[c] ? 0 : (m_cnt[c] < QC ? m_cnt[c] + 1 : QC);
        m_onp[c] = on_p[c];
        m_st[c]  = ns[c];
      end
      if (st_go) begin m_busy = 1; m_tcnt = SC - 1; end
      else if (m_busy != 0) begin
        if (m_tcnt == 0) m_busy = 0; else m_tcnt--;
      end
      if (m_pw == 0) begin if (ok) begin m_pw = 1; m_pcnt = PC - 1; end end
      else if (m_pw == 1) begin
        if (!ok) m_pw = 0; else if (m_pcnt == 0) m_pw = 2; else m_pcnt--;
      end else if (!ok) m_pw = 0;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1 por_o", por, (m_pw == 1));
      chk("R4 gate0", gate[0], (m_st[0] == 3));
      chk("R4 gate1", gate[1], (m_st[1] == 3));
      chk("R2 ctl0", ctl_on[0], m_ctl[0]);
      chk("R2 ctl1", ctl_on[1], m_ctl[1]);
      chk("R7 busy", busy, m_busy);
      chk("R10 status", status, {ov_ok[1], uv_ok[1], ov_ok[0], uv_ok[0]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R2 reset gate", gate, 0);
    chk("R1 reset por", por, 0);

    vdd_ok = 2'b11; intvcc_ok = 1'b1;
    step(2);
    chk("R1 pulse high", por, 1);
    step(6);
    chk("R1 pulse ended", por, 0);

    // R3 bounce in the window
    uv_ok = 2'b11; ov_ok = 2'b11; on_p = 2'b01; en_n = 2'b10;
    step(5); en_n = 2'b11; step(1); en_n = 2'b10;
    step(9);
    chk("R3 no gate before window", gate[0], 0);
    step(20);
    chk("R4 gate0 on", gate[0], 1);
    chk("R4 ctl0 loaded", ctl_on[0], 1);

    // R7 host turn-on waits for timer
    en_n = 2'b11; step(20);
    en_n = 2'b00;
    step(14);
    we = 2'b10; wd = 2'b10; step(1); we = 2'b00; wd = 2'b00;
    step(2);
    chk("R7 ch1 held", gate[1], 0);
    chk("R7 timer busy", busy, 1);
    step(20);
    chk("R5 ch1 on after host write", gate[1], 1);

    // R9 fault
    fault = 2'b01; step(1);
    chk("R9 gate0 off", gate[0], 0);
    fault = 2'b00;
    step(40);
    chk("R9 gate0 requalified", gate[0], 1);

    // R8 pin bypass
    en_n = 2'b11; step(3);
    on_p = 2'b10; en_n = 2'b00;
    step(14);
    we = 2'b01; wd = 2'b01; step(1); we = 2'b00; wd = 2'b00;
    step(2);
    chk("R7 ch0 waiting", gate[0], 0);
    on_p = 2'b11;
    step(2);
    chk("R8 bypass gate0", gate[0], 1);
    chk("R8 timer still busy", busy, 1);

    // R6 coupled
    en_n = 2'b11; step(3);
    couple = 1'b0; on_p = 2'b11; en_n = 2'b10;
    step(30);
    chk("R6 single channel stays off", gate, 0);
    en_n = 2'b00;
    step(15);
    chk("R6 pair on", gate, 3);
    uv_ok = 2'b01;
    step(1);
    chk("R6 pair off", gate, 0);
    chk("R10 status uv1 low", status, 4'b1011);
    uv_ok = 2'b11; on_p = 2'b01;
    step(15);
    chk("R6 needs both bits", gate, 0);
    chk("R4 ctl pair", ctl_on, 1);
    we = 2'b10; wd = 2'b10; step(1); we = 2'b00; wd = 2'b00;
    step(3);
    chk("R5 pair on via host", gate, 3);

    // R1 supply loss and new pulse, R2 control cleared
    intvcc_ok = 1'b0;
    step(2);
    chk("R1 gates off on loss", gate, 0);
    intvcc_ok = 1'b1;
    step(2);
    chk("R2 ctl cleared", ctl_on, 0);
    chk("R2 por during", por, 1);
    step(5);
    chk("R1 por done", por, 0);
    step(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule